// File: doc/BRIEF.md
# Pulse-Swallowing Millisecond Prescaler

This block turns a stream of reference-edge strobes from a 32.768 kHz source into a 1 kHz increment pulse for a timekeeping counter chain. The block runs on a fast system clock. Each reference edge arrives as a one-cycle strobe that has already been synchronized to that clock. The block first discards 3 edges in every group of 128, which leaves an even 32000 accepted edges per second. It then divides the accepted edges by 32. Because of the discarded edges, the increment intervals are deliberately uneven, but the number of increments over one second is exact.

The three discarded positions are spread across each group, so no increment interval absorbs more than one of them. A seconds marker fires together with every thousandth increment, which gives it a period of exactly 32768 reference edges. A test-mode input bypasses the prescaler, and every reference edge then becomes an increment.

Top module: `msec_prescaler`

## Requirements
- R1: A synchronous active-high `rst` clears every counter. In the cycle after a clock edge that samples `rst` high, both `inc_pulse` and `sec_mark` are 0. A `ref_tick` that arrives while `rst` is high is ignored.
- R2: Outside test mode, reference edges are numbered modulo 128 from reset, starting at 0. The edges at positions 0, 43 and 86 are discarded, so exactly 3 of every 128 consecutive edges are dropped.
- R3: After reset, the first `inc_pulse` follows the 33rd reference edge (index 32). This is the 32nd accepted edge, because edge 0 is discarded.
- R4: An increment is produced on every 32nd accepted edge. The number of reference edges between successive increments is always 32 or 33.
- R5: Outside test mode, every 32768 consecutive reference edges counted from reset produce exactly 1000 increments.
- R6: `inc_pulse` is high for exactly one system-clock cycle. That cycle is the one right after the clock edge that sampled the causing `ref_tick`.
- R7: `sec_mark` is high only together with `inc_pulse`, on every 1000th increment since reset. Outside test mode it first appears on reference edge index 32767 and then repeats every 32768 edges exactly.
- R8: While `test_mode` is 1, every `ref_tick` produces an `inc_pulse` in the following cycle. Increments made in test mode also advance the 1000-increment count for `sec_mark`.
- R9: While `test_mode` is 1, the edge-group position and the divide-by-32 phase hold their values. After `test_mode` returns to 0, division resumes from that held phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference edge, already synchronized |
| test_mode | input | 1 | 1: forward every reference edge as an increment |
| inc_pulse | output | 1 | One-cycle 1 kHz increment pulse |
| sec_mark | output | 1 | One-cycle marker on every 1000th increment |

## Verification
The assertions take `ref_tick` to be a single-cycle strobe. They also take `test_mode` to change only between strobes, so that an increment interval is never shared by the two modes. The interval check is therefore disarmed once test mode has been used since reset. The stimulus spaces strobes two system cycles apart and changes `test_mode` only in an idle cycle. The one-cycle check on `inc_pulse` depends on that spacing.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

  // Discarded slots sit at multiples of ceil(group_len / n_drop), up to n_drop of them.
  function automatic logic is_drop_slot(input int unsigned idx,
                                        input int unsigned group_len,
                                        input int unsigned n_drop);
    int unsigned step;
    step = (group_len + n_drop - 1) / n_drop;
    return ((idx % step) == 0) && ((idx / step) < n_drop);
  endfunction

  // Value that follows cur in a modulo-modulus count.
  function automatic int unsigned next_mod(input int unsigned cur,
                                           input int unsigned modulus);
    return (cur == modulus - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/edge_swallower.sv
module edge_swallower #(
  parameter int unsigned GROUP_LEN = 128,
  parameter int unsigned N_DROP    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic hold_i,
  output logic accept_o,
  output logic drop_o
);
  import prescale_pkg::*;

  localparam int unsigned CW = $clog2(GROUP_LEN);

  logic [CW-1:0] slot_q;
  logic          live;

  assign live     = tick_i & ~hold_i;
  assign drop_o   = live & is_drop_slot(32'(slot_q), GROUP_LEN, N_DROP);
  assign accept_o = live & ~drop_o;

  always_ff @(posedge clk) begin
    if (rst)       slot_q <= '0;
    else if (live) slot_q <= CW'(next_mod(32'(slot_q), GROUP_LEN));
  end
endmodule

// File: rtl/mod_counter.sv
module mod_counter #(
  parameter int unsigned MODULUS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic wrap_o
);
  import prescale_pkg::*;

  localparam int unsigned CW = $clog2(MODULUS);

  logic [CW-1:0] cnt_q;

  assign wrap_o = en_i & (cnt_q == CW'(MODULUS - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (en_i) cnt_q <= CW'(next_mod(32'(cnt_q), MODULUS));
  end
endmodule

// File: rtl/msec_prescaler.sv
module msec_prescaler #(
  parameter int unsigned GROUP_LEN = 128,
  parameter int unsigned N_DROP    = 3,
  parameter int unsigned DIV_RATIO = 32,
  parameter int unsigned SEC_INCS  = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic test_mode,
  output logic inc_pulse,
  output logic sec_mark
);
  // Named internal events, observed by the bound checker.
  logic accept_w;
  logic drop_w;
  logic div_wrap_w;
  logic inc_evt_w;
  logic sec_wrap_w;

  edge_swallower #(.GROUP_LEN(GROUP_LEN), .N_DROP(N_DROP)) u_swallow (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (ref_tick),
    .hold_i   (test_mode),
    .accept_o (accept_w),
    .drop_o   (drop_w)
  );

  mod_counter #(.MODULUS(DIV_RATIO)) u_div (
    .clk    (clk),
    .rst    (rst),
    .en_i   (accept_w),
    .wrap_o (div_wrap_w)
  );

  assign inc_evt_w = test_mode ? ref_tick : div_wrap_w;

  mod_counter #(.MODULUS(SEC_INCS)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .en_i   (inc_evt_w),
    .wrap_o (sec_wrap_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_pulse <= 1'b0;
      sec_mark  <= 1'b0;
    end else begin
      inc_pulse <= inc_evt_w;
      sec_mark  <= sec_wrap_w;
    end
  end
endmodule

// File: rtl/msec_prescaler_chk.sv
module msec_prescaler_chk #(
  parameter int unsigned GROUP_LEN = 128,
  parameter int unsigned N_DROP    = 3,
  parameter int unsigned DIV_RATIO = 32,
  parameter int unsigned SEC_INCS  = 1000
) (
  input logic clk,
  input logic rst,
  input logic ref_tick,
  input logic test_mode,
  input logic drop_w,
  input logic inc_pulse,
  input logic sec_mark
);
  localparam int unsigned GW = $clog2(GROUP_LEN);

  logic          live;
  logic [GW-1:0] grp_pos_q;
  logic [15:0]   grp_drops_q;
  logic [15:0]   grp_total_q;
  logic          grp_done_q;
  logic [15:0]   gap_q;
  logic          dirty_q;
  logic [15:0]   incs_q;

  assign live = ref_tick & ~test_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_pos_q   <= '0;
      grp_drops_q <= '0;
      grp_total_q <= '0;
      grp_done_q  <= 1'b0;
    end else begin
      grp_done_q <= 1'b0;
      if (live) begin
        if (grp_pos_q == GW'(GROUP_LEN - 1)) begin
          grp_pos_q   <= '0;
          grp_done_q  <= 1'b1;
          grp_total_q <= grp_drops_q + 16'(drop_w);
          grp_drops_q <= '0;
        end else begin
          grp_pos_q   <= grp_pos_q + 1'b1;
          grp_drops_q <= grp_drops_q + 16'(drop_w);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      dirty_q <= 1'b0;
      incs_q  <= '0;
    end else begin
      if (test_mode) dirty_q <= 1'b1;
      if (inc_pulse)  gap_q <= 16'(live);
      else if (live)  gap_q <= gap_q + 1'b1;
      if (inc_pulse)  incs_q <= sec_mark ? '0 : incs_q + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!inc_pulse && !sec_mark)); // R1

  AST_DROP_RATE: assert property (@(posedge clk) disable iff (rst)
    grp_done_q |-> (grp_total_q == 16'(N_DROP))); // R2

  AST_INC_SPACING: assert property (@(posedge clk) disable iff (rst)
    (inc_pulse && !dirty_q) |-> (gap_q == 16'(DIV_RATIO) || gap_q == 16'(DIV_RATIO + 1))); // R4

  AST_INC_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
    inc_pulse |-> $past(ref_tick)); // R6

  AST_SEC_WITH_INC: assert property (@(posedge clk) disable iff (rst)
    sec_mark |-> inc_pulse); // R7

  AST_SEC_COUNT: assert property (@(posedge clk) disable iff (rst)
    sec_mark |-> (incs_q == 16'(SEC_INCS - 1))); // R7

  AST_TEST_PASS: assert property (@(posedge clk) disable iff (rst)
    (test_mode && ref_tick) |=> inc_pulse); // R8
endmodule

bind msec_prescaler msec_prescaler_chk #(
  .GROUP_LEN(GROUP_LEN), .N_DROP(N_DROP), .DIV_RATIO(DIV_RATIO), .SEC_INCS(SEC_INCS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_tick  (ref_tick),
  .test_mode (test_mode),
  .drop_w    (drop_w),
  .inc_pulse (inc_pulse),
  .sec_mark  (sec_mark)
);

// File: tb/msec_prescaler_test.sv
module msec_prescaler_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic test_mode = 1'b0;
  logic inc_pulse;
  logic sec_mark;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msec_prescaler uut (
    .clk       (clk),
    .rst       (rst),
    .ref_tick  (ref_tick),
    .test_mode (test_mode),
    .inc_pulse (inc_pulse),
    .sec_mark  (sec_mark)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Edge e (index since reset) is discarded at positions 0, 43 and 86 of each group of 128.
  function automatic bit dropped(input int e);
    int r;
    r = e % 128;
    return (r == 0) || (r == 43) || (r == 86);
  endfunction

  // Number of accepted edges among indices 0..e.
  function automatic int accepted_thru(input int e);
    int r;
    r = e % 128;
    return e + 1 - ((e / 128) * 3 + 1 + int'(r >= 43) + int'(r >= 86));
  endfunction

  function automatic bit inc_due(input int e);
    return !dropped(e) && (accepted_thru(e) % 32 == 0);
  endfunction

  // One strobe, then one idle cycle. Outputs are sampled after the edge that took the strobe.
  task automatic send_edge(output bit got_inc, output bit got_sec);
    @(negedge clk);
    check(inc_pulse == 1'b0, "R6 pulse lasts one cycle", int'(inc_pulse), 0);
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    got_inc = inc_pulse;
    got_sec = sec_mark;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    ref_tick = 1'b1;
    @(negedge clk);
    ref_tick = 1'b0;
    check(inc_pulse == 1'b0 && sec_mark == 1'b0, "R1 outputs low in reset",
          int'({inc_pulse, sec_mark}), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(inc_pulse == 1'b0, "R1 reset inc_pulse", int'(inc_pulse), 0);
    check(sec_mark == 1'b0, "R1 reset sec_mark", int'(sec_mark), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_two_seconds();
    int incs = 0;
    bit gi, gs;
    do_reset();
    for (int e = 0; e < 65536; e++) begin
      bit exp_i, exp_s;
      send_edge(gi, gs);
      exp_i = inc_due(e);
      exp_s = exp_i && (accepted_thru(e) % 32000 == 0);
      if (gi) incs++;
      if (e <= 32)
        check(gi == exp_i, "R3 first increment", int'(gi), int'(exp_i));
      else if (e < 128)
        check(gi == exp_i, "R2 drop positions", int'(gi), int'(exp_i));
      else
        check(gi == exp_i, "R4 increment spacing", int'(gi), int'(exp_i));
      check(gs == exp_s, "R7 seconds marker", int'(gs), int'(exp_s));
      if (e == 32767 || e == 65535) begin
        check(incs == 1000, "R5 increments per second", incs, 1000);
        incs = 0;
      end
    end
  endtask

  task automatic t_mid_reset();
    bit gi, gs;
    for (int e = 0; e < 40; e++) send_edge(gi, gs);
    do_reset();
    for (int e = 0; e <= 40; e++) begin
      send_edge(gi, gs);
      check(gi == inc_due(e), "R1 R3 restart after reset", int'(gi), int'(inc_due(e)));
    end
  endtask

  task automatic t_test_mode();
    bit gi, gs;
    do_reset();
    for (int e = 0; e < 50; e++) begin
      send_edge(gi, gs);
      check(gi == inc_due(e), "R4 before test mode", int'(gi), int'(inc_due(e)));
    end
    @(negedge clk);
    test_mode = 1'b1;
    // One normal increment already counted, so the 999th test edge completes 1000.
    for (int i = 0; i < 1000; i++) begin
      send_edge(gi, gs);
      check(gi == 1'b1, "R8 test edge increments", int'(gi), 1);
      check(gs == (i == 998), "R8 test edges feed seconds", int'(gs), int'(i == 998));
    end
    @(negedge clk);
    test_mode = 1'b0;
    for (int e = 50; e < 200; e++) begin
      send_edge(gi, gs);
      check(gi == inc_due(e), "R9 phase resumes", int'(gi), int'(inc_due(e)));
      check(gs == 1'b0, "R9 no stray marker", int'(gs), 0);
    end
  endtask

  initial begin
    t_reset_state();
    t_two_seconds();
    t_mid_reset();
    t_test_mode();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule